// File: doc/BRIEF.md
# User RAM Clear Sequencer

This block owns a small byte-wide user memory (114 bytes by default) and can wipe it to all ones when an external active-low clear pin falls. The wipe happens only when the clear-enable input is high. A sequencer then writes 0xFF to one byte per cycle, from the lowest address up. After the last byte it raises a sticky completion flag. When the supply-good input and the interrupt-enable input are both high, that flag pulls an active-low interrupt line. Software acknowledges the event by pulsing a flag-clear input, which stands for a write of zero to the flag. The interrupt line then goes high again unless another source is pending.

The processor reaches the memory through a valid/ready request channel. Once the sequencer starts, `req_ready` stays low for a fixed recovery window of `REC_CYCLES` clocks. While `req_ready` is low, a request must be held until it is accepted. Read data comes back on a response pulse one cycle after the request is accepted. The response channel has no ready signal, so the requester must always take it. `REC_CYCLES` must be at least the byte count, so the recovery window always covers the whole sweep. The clear pin is synchronized with two flops before the falling edge is detected.

Top module: `user_ram_wiper`

## Requirements
- R1: When `clr_pin_n` falls while `cfg_clr_en` is 1 and no sweep is running, every byte at addresses 0 to N_BYTES-1 reads back as 0xFF once the sweep ends.
- R2: While `cfg_clr_en` is 0, a falling edge on `clr_pin_n` leaves the memory contents, `done_flag` and `req_ready` unchanged.
- R3: `done_flag` goes to 1 when the last byte has been written. It stays at 1 until a `flag_clr` pulse.
- R4: `irq_n` is 0 whenever `done_flag`, `cfg_irq_en` and `vcc_ok` are all 1, or whenever `other_irq` is 1. Otherwise `irq_n` is 1.
- R5: A one-cycle `flag_clr` pulse clears `done_flag`. `irq_n` then returns to 1 only if `other_irq` is 0.
- R6: After a detected falling edge, `req_ready` is 0 for exactly `REC_CYCLES` consecutive cycles and then returns to 1.
- R7: A second falling edge on `clr_pin_n` while a sweep is running is ignored: it does not lengthen the recovery window.
- R8: An accepted write stores `req_wdata` at `req_addr`. An accepted read (`req_we`=0) produces `rsp_valid`=1 with the stored byte on `rsp_data` one cycle later.
- R9: A write to an address of N_BYTES or above is dropped. A read from such an address returns 0x00.
- R10: The clear starts only on a high-to-low transition. A pin already held low when `cfg_clr_en` rises starts nothing.
- R11: Out of reset, `done_flag` is 0, `req_ready` is 1, `rsp_valid` is 0, and `irq_n` is 1 while `other_irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr_pin_n | input | 1 | Asynchronous clear pin, active on its falling edge |
| cfg_clr_en | input | 1 | Enables the pin-triggered clear |
| cfg_irq_en | input | 1 | Enables the completion interrupt |
| vcc_ok | input | 1 | Main supply present |
| other_irq | input | 1 | Another interrupt source is pending |
| flag_clr | input | 1 | Pulse that writes zero to the completion flag |
| req_valid | input | 1 | Bus request valid |
| req_ready | output | 1 | Bus request accepted (0 during recovery) |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data valid, one-cycle pulse |
| rsp_data | output | 8 | Read data |
| done_flag | output | 1 | Sticky clear-complete flag |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench plants distinct bytes at the first, last and a middle address before a wipe. A sweep that skipped an endpoint or stopped one short would leave one of those bytes visible. It counts the low cycles of `req_ready` cycle by cycle. A timer that started on the wrong cycle, or was restarted by a second pin edge during a sweep, would show up as a count other than `REC_CYCLES`. A pin pulse with the enable off, and a pin held low while the enable rises, check that only a true enabled edge acts. The interrupt is checked with the supply flag off, with the enable off and with another source pending. This catches a flag that drives the line unconditionally, or a flag clear that forces the line high.

// File: rtl/urw_pkg.sv
package urw_pkg;
  typedef enum logic {SW_IDLE = 1'b0, SW_RUN = 1'b1} sweep_state_e;
  localparam logic [7:0] FILL_BYTE = 8'hFF;
endpackage

// File: rtl/urw_pin_edge.sv
module urw_pin_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic fall
);
  logic s1, s2, prev;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1   <= 1'b1;
      s2   <= 1'b1;
      prev <= 1'b1;
    end else begin
      s1   <= pin_n;
      s2   <= s1;
      prev <= s2;
    end
  end
  assign fall = prev & ~s2;
endmodule

// File: rtl/urw_sweep.sv
module urw_sweep
  import urw_pkg::*;
#(
  parameter int N_BYTES = 114,
  localparam int ADDR_W = $clog2(N_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic [ADDR_W-1:0] addr,
  output logic              last
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(N_BYTES - 1);
  sweep_state_e state;

  assign busy = (state == SW_RUN);
  assign last = busy && (addr == LAST_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= SW_IDLE;
      addr  <= '0;
    end else begin
      unique case (state)
        SW_IDLE: if (start) begin
          state <= SW_RUN;
          addr  <= '0;
        end
        SW_RUN: begin
          if (addr == LAST_ADDR) state <= SW_IDLE;
          else                   addr  <= addr + 1'b1;
        end
        default: state <= SW_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/urw_lock_timer.sv
module urw_lock_timer #(
  parameter int REC_CYCLES = 130,
  localparam int CNT_W = $clog2(REC_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic locked
);
  logic [CNT_W-1:0] cnt;
  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= CNT_W'(REC_CYCLES);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end
  assign locked = (cnt != '0);
endmodule

// File: rtl/urw_ram.sv
module urw_ram
  import urw_pkg::*;
#(
  parameter int N_BYTES = 114,
  localparam int ADDR_W = $clog2(N_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill_we,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic              bus_fire,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic              rd_valid,
  output logic [7:0]        rd_data
);
  logic [7:0] mem [N_BYTES];
  logic       in_range;

  assign in_range = (int'(bus_addr) < N_BYTES);

  always_ff @(posedge clk) begin
    if (fill_we)
      mem[fill_addr] <= FILL_BYTE;
    else if (bus_fire && bus_we && in_range)
      mem[bus_addr] <= bus_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= bus_fire && !bus_we;
      if (bus_fire && !bus_we)
        rd_data <= in_range ? mem[bus_addr] : 8'h00;
    end
  end
endmodule

// File: rtl/user_ram_wiper.sv
module user_ram_wiper #(
  parameter int N_BYTES    = 114,
  parameter int REC_CYCLES = 130,
  localparam int ADDR_W    = $clog2(N_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_pin_n,
  input  logic              cfg_clr_en,
  input  logic              cfg_irq_en,
  input  logic              vcc_ok,
  input  logic              other_irq,
  input  logic              flag_clr,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_wdata,
  output logic              rsp_valid,
  output logic [7:0]        rsp_data,
  output logic              done_flag,
  output logic              irq_n
);
  logic              pin_fall;
  logic              start;
  logic              sweep_busy;
  logic              sweep_last;
  logic [ADDR_W-1:0] sweep_addr;
  logic              lock_active;

  urw_pin_edge u_edge (
    .clk(clk), .rst_n(rst_n), .pin_n(clr_pin_n), .fall(pin_fall)
  );

  assign start = pin_fall && cfg_clr_en && !sweep_busy;

  urw_sweep #(.N_BYTES(N_BYTES)) u_sweep (
    .clk(clk), .rst_n(rst_n), .start(start),
    .busy(sweep_busy), .addr(sweep_addr), .last(sweep_last)
  );

  urw_lock_timer #(.REC_CYCLES(REC_CYCLES)) u_lock (
    .clk(clk), .rst_n(rst_n), .load(start), .locked(lock_active)
  );

  assign req_ready = !lock_active && !sweep_busy;

  urw_ram #(.N_BYTES(N_BYTES)) u_ram (
    .clk(clk), .rst_n(rst_n),
    .fill_we(sweep_busy), .fill_addr(sweep_addr),
    .bus_fire(req_valid && req_ready), .bus_we(req_we),
    .bus_addr(req_addr), .bus_wdata(req_wdata),
    .rd_valid(rsp_valid), .rd_data(rsp_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)          done_flag <= 1'b0;
    else if (sweep_last) done_flag <= 1'b1;
    else if (flag_clr)   done_flag <= 1'b0;
  end

  assign irq_n = !((done_flag && cfg_irq_en && vcc_ok) || other_irq);
endmodule

// File: rtl/urw_checker.sv
module urw_checker #(
  parameter int N_BYTES = 114,
  localparam int ADDR_W = $clog2(N_BYTES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_clr_en,
  input logic              cfg_irq_en,
  input logic              vcc_ok,
  input logic              other_irq,
  input logic              req_ready,
  input logic              done_flag,
  input logic              irq_n,
  input logic              sweep_busy,
  input logic [ADDR_W-1:0] sweep_addr,
  input logic              lock_active
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(N_BYTES - 1);

  AST_BUSY_BLOCKS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_busy |-> !req_ready) else $error("busy but ready"); // R6

  AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sweep_busy) |-> $past(cfg_clr_en)) else $error("start without enable"); // R2

  AST_START_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sweep_busy) |-> (sweep_addr == '0) && lock_active) else $error("bad start"); // R1

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (sweep_busy && sweep_addr != LAST_ADDR) |=> sweep_busy && (sweep_addr == $past(sweep_addr) + 1'b1))
    else $error("address skip"); // R1

  AST_FLAG_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (sweep_busy && sweep_addr == LAST_ADDR) |=> done_flag && !sweep_busy) else $error("no flag"); // R3

  AST_IRQ_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    ((done_flag && cfg_irq_en && vcc_ok) || other_irq) |-> !irq_n) else $error("irq missing"); // R4

  AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!done_flag && !other_irq) |-> irq_n) else $error("irq spurious"); // R5
endmodule

bind user_ram_wiper urw_checker #(.N_BYTES(N_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_clr_en(cfg_clr_en), .cfg_irq_en(cfg_irq_en),
  .vcc_ok(vcc_ok), .other_irq(other_irq), .req_ready(req_ready),
  .done_flag(done_flag), .irq_n(irq_n), .sweep_busy(sweep_busy),
  .sweep_addr(sweep_addr), .lock_active(lock_active)
);

// File: tb/user_ram_wiper_test.sv
module user_ram_wiper_test;
  localparam int CLK_PERIOD = 10;
  localparam int NB  = 114;
  localparam int REC = 130;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr_pin_n = 1'b1, cfg_clr_en = 1'b0, cfg_irq_en = 1'b0, vcc_ok = 1'b1;
  logic other_irq = 1'b0, flag_clr = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [6:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic req_ready, rsp_valid, done_flag, irq_n;
  logic [7:0] rsp_data;

  int vectors = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  user_ram_wiper #(.N_BYTES(NB), .REC_CYCLES(REC)) uut (
    .clk(clk), .rst_n(rst_n), .clr_pin_n(clr_pin_n), .cfg_clr_en(cfg_clr_en),
    .cfg_irq_en(cfg_irq_en), .vcc_ok(vcc_ok), .other_irq(other_irq),
    .flag_clr(flag_clr), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .done_flag(done_flag), .irq_n(irq_n)
  );

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input int a, input int d);
    @(negedge clk);
    check("R8 ready before write", int'(req_ready), 1);
    req_valid = 1'b1; req_we = 1'b1; req_addr = 7'(a); req_wdata = 8'(d);
    @(negedge clk);
    req_valid = 1'b0; req_we = 1'b0;
  endtask

  task automatic bus_read(input int a, output int d, output int v);
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b0; req_addr = 7'(a);
    @(negedge clk);
    req_valid = 1'b0;
    d = int'(rsp_data); v = int'(rsp_valid);
  endtask

  task automatic pulse_flag_clr;
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
  endtask

  // Drop the pin and count cycles with req_ready low; optional retrigger.
  task automatic run_clear(input bit retrig, output int low_cnt);
    low_cnt = 0;
    @(negedge clk); clr_pin_n = 1'b0;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (retrig && i == 20) clr_pin_n = 1'b1;
      if (retrig && i == 24) clr_pin_n = 1'b0;
      if (!req_ready) low_cnt++;
      else if (low_cnt > 0) break;
    end
    clr_pin_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R11 done_flag", int'(done_flag), 0);
    check("R11 req_ready", int'(req_ready), 1);
    check("R11 rsp_valid", int'(rsp_valid), 0);
    check("R11 irq_n", int'(irq_n), 1);
  endtask

  task automatic t_bus;
    int d, v;
    bus_write(5, 8'h3C);
    bus_read(5, d, v);
    check("R8 rsp_valid", v, 1);
    check("R8 rsp_data", d, 8'h3C);
    @(negedge clk);
    check("R8 rsp_valid one pulse", int'(rsp_valid), 0);
    bus_write(120, 8'h77);
    bus_read(120, d, v);
    check("R9 out of range read", d, 0);
    check("R9 out of range valid", v, 1);
    bus_read(120 - 64, d, v);
    bus_write(56, d ^ 8'h01);
    bus_read(56, d, v);
    bus_write(113, 8'h11);
    bus_read(113, d, v);
    check("R9 last in-range byte intact", d, 8'h11);
  endtask

  task automatic t_disabled;
    int d, v, lc;
    cfg_clr_en = 1'b0;
    bus_write(3, 8'h5A);
    run_clear(1'b0, lc);
    check("R2 ready untouched", lc, 0);
    check("R2 flag untouched", int'(done_flag), 0);
    bus_read(3, d, v);
    check("R2 ram untouched", d, 8'h5A);
  endtask

  task automatic t_level_only;
    int d, v;
    @(negedge clk); clr_pin_n = 1'b0;
    repeat (5) @(negedge clk);
    cfg_clr_en = 1'b1;
    repeat (10) @(negedge clk);
    check("R10 no start on level", int'(req_ready), 1);
    check("R10 flag stays 0", int'(done_flag), 0);
    bus_read(3, d, v);
    check("R10 ram intact", d, 8'h5A);
    clr_pin_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic t_full_clear;
    int d, v, lc, bad;
    cfg_clr_en = 1'b1; cfg_irq_en = 1'b1; vcc_ok = 1'b1;
    bus_write(0, 8'h00);
    bus_write(50, 8'hAB);
    bus_write(113, 8'h12);
    run_clear(1'b0, lc);
    check("R6 lockout length", lc, REC);
    check("R3 flag set", int'(done_flag), 1);
    check("R4 irq low", int'(irq_n), 0);
    bad = 0;
    for (int a = 0; a < NB; a++) begin
      bus_read(a, d, v);
      if (d != 8'hFF) bad++;
    end
    check("R1 bytes not 0xFF", bad, 0);
    repeat (10) @(negedge clk);
    check("R3 flag sticky", int'(done_flag), 1);
    other_irq = 1'b1;
    pulse_flag_clr();
    check("R5 flag cleared", int'(done_flag), 0);
    check("R5 irq held by other source", int'(irq_n), 0);
    other_irq = 1'b0;
    #1;
    check("R5 irq released", int'(irq_n), 1);
  endtask

  task automatic t_retrigger;
    int lc;
    cfg_clr_en = 1'b1; cfg_irq_en = 1'b0;
    run_clear(1'b1, lc);
    check("R7 lockout not extended", lc, REC);
    check("R3 flag after retrigger run", int'(done_flag), 1);
    check("R4 irq high when disabled", int'(irq_n), 1);
    pulse_flag_clr();
  endtask

  task automatic t_no_vcc;
    int lc;
    cfg_clr_en = 1'b1; cfg_irq_en = 1'b1; vcc_ok = 1'b0;
    run_clear(1'b0, lc);
    check("R3 flag without supply", int'(done_flag), 1);
    check("R4 irq high without supply", int'(irq_n), 1);
    vcc_ok = 1'b1;
    #1;
    check("R4 irq low with supply", int'(irq_n), 0);
    pulse_flag_clr();
    check("R5 irq high after clear", int'(irq_n), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bus();
    t_disabled();
    t_level_only();
    t_full_clear();
    t_retrigger();
    t_no_vcc();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    vectors++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule